// File: doc/BRIEF.md
# PWM Dead-Time Insertion Unit

This block sits between up to three pulse-width-modulated channel signals and the pads of a half-bridge driver. For each channel it produces a high-side (primary) drive and a low-side (complementary) drive. A programmable guard interval separates them, so the two switches of a leg are never on together. The guard interval after a rising input (before the primary turns on) and the one after a falling input (before the complementary turns on) are set independently. Both are counted in ticks of a local power-of-two prescaler.

Output polarity is configurable: the primaries can be made active-low, and the complementaries can be inverted on top of that. A six-bit mask decides which pins the block drives at all. Four fault sources can each be enabled separately: a processor lockup indication, a debug-halt indication and two external fault lines. An enabled source that asserts latches a sticky flag. While any flag is set, the selected safe action overrides normal drive. An optional auto-restart lets the debug-halt flag drop by itself once the halt ends.

Top module: `dti_unit`

## Requirements
- R1: Under synchronous reset all pins, output enables and fault flags are 0.
- R2: A channel's primary becomes active only after its input has stayed high for `rise_dly` prescaler ticks, and its complementary only after the input has stayed low for `fall_dly` ticks. Any input change deactivates both at once. With a delay of 0 the drive follows on the next clock. A pin reflects the internal state one clock later.
- R3: The primary and complementary of one channel are never active in the same cycle, for any input pattern.
- R4: A prescaler tick occurs once every 2^`presc_sel` clocks while enabled, so `presc_sel` = 0 ticks every clock.
- R5: The primary pin level is `active ^ pri_active_low`, and the complementary pin level is `active ^ pri_active_low ^ cmp_invert`. The inactive level is the same expression with active = 0.
- R6: `out_mask` bit i gates primary i and bit NCH+i gates complementary i. A gated-off pin has its output enable at 0 and sits at its inactive level.
- R7: While a fault flag is set, `fault_act` = 1 drives every pin to its inactive level and `fault_act` = 2 drives every pin to 0. Output enables still follow the mask. `fault_act` = 0 leaves the drive untouched.
- R8: While a fault flag is set with `fault_act` = 3, all output enables are 0 and the pins sit at their inactive level.
- R9: Flag bits are ordered {ext1, ext0, halt, lockup}. A flag sets on the clock after its source is high with its `fault_src_en` bit set. An unenabled source has no effect. A flag stays set until its `fault_clr` bit is pulsed, and a set in the same cycle wins over a clear.
- R10: With `auto_restart` high, the halt flag clears on the clock after the halt input is low, and normal drive resumes.
- R11: With `enable` low, all output enables are 0, pins are at their inactive level, and the dead-time and prescaler state is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Unit enable |
| pwm_in | input | NCH | Channel PWM inputs |
| presc_sel | input | SEL_W | Prescaler exponent, divide by 2^n |
| rise_dly | input | DLY_W | Ticks before primary turns on |
| fall_dly | input | DLY_W | Ticks before complementary turns on |
| pri_active_low | input | 1 | Primaries active-low |
| cmp_invert | input | 1 | Extra inversion of complementaries |
| out_mask | input | 2*NCH | Per-pin drive enables |
| fault_act | input | 2 | 0 none, 1 inactive, 2 clear, 3 tristate |
| lockup_in | input | 1 | Processor lockup fault source |
| halt_in | input | 1 | Debug halt fault source |
| ext_fault_in | input | 2 | External fault sources |
| fault_src_en | input | 4 | Source enables {ext1, ext0, halt, lockup} |
| fault_clr | input | 4 | Flag clear pulses, same order |
| auto_restart | input | 1 | Halt flag self-clears when halt ends |
| pri_out | output | NCH | Primary pins |
| cmp_out | output | NCH | Complementary pins |
| pri_oe | output | NCH | Primary output enables |
| cmp_oe | output | NCH | Complementary output enables |
| fault_flags | output | 4 | Latched fault flags |
| fault_active | output | 1 | Any flag set |

## Verification
Two pairs of events are forced into the same cycle. The first is a fault flag rising in the very cycle a channel's guard interval expires. The second is a clear pulse landing in the cycle its source is asserted. In the second case the flag must stay set, and in the first the override must win over the newly activated drive. A behavioural model in the bench keeps a tick count since the last input change and the latched flags. It predicts every pin and enable on every clock, so any cycle where the two orderings are resolved differently shows up as a miscompare.

// File: rtl/dti_pkg.sv
package dti_pkg;
  typedef enum logic [1:0] {
    FA_NONE     = 2'd0,
    FA_INACTIVE = 2'd1,
    FA_CLEAR    = 2'd2,
    FA_TRISTATE = 2'd3
  } fault_act_e;

  localparam int NUM_SRC    = 4;
  localparam int SRC_LOCKUP = 0;
  localparam int SRC_HALT   = 1;
  localparam int SRC_EXT0   = 2;
  localparam int SRC_EXT1   = 3;
endpackage

// File: rtl/dti_prescaler.sv
module dti_prescaler #(
  parameter int PRE_MAX = 10,
  parameter int SEL_W   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [PRE_MAX-1:0] cnt_q;
  logic [PRE_MAX-1:0] mask;

  always_comb begin
    mask = '0;
    for (int b = 0; b < PRE_MAX; b++)
      if (b < int'(sel)) mask[b] = 1'b1;
  end

  assign tick = en && ((cnt_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || !en) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  // R4
  tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && sel != '0) |=> (!tick || sel == '0));
endmodule

// File: rtl/dti_channel.sv
module dti_channel #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             tick,
  input  logic             pwm,
  input  logic [DLY_W-1:0] rise_dly,
  input  logic [DLY_W-1:0] fall_dly,
  output logic             pri_act,
  output logic             cmp_act
);
  logic             lvl_q;
  logic [DLY_W-1:0] cnt_q;
  logic [DLY_W-1:0] cnt_n;
  logic [DLY_W-1:0] need;
  logic             done;

  always_comb begin
    cnt_n = (pwm == lvl_q) ? cnt_q : '0;
    need  = pwm ? rise_dly : fall_dly;
    done  = (cnt_n >= need);
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      lvl_q   <= 1'b0;
      cnt_q   <= '0;
      pri_act <= 1'b0;
      cmp_act <= 1'b0;
    end else begin
      lvl_q   <= pwm;
      pri_act <= pwm & done;
      cmp_act <= ~pwm & done;
      if (!done && tick) cnt_q <= cnt_n + 1'b1;
      else               cnt_q <= cnt_n;
    end
  end

  // R3
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(pri_act && cmp_act));
  // R2
  edge_kills_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (en && pwm != lvl_q) |=> (!pri_act || rise_dly == '0 || $past(rise_dly) == '0));
endmodule

// File: rtl/dti_fault.sv
module dti_fault
  import dti_pkg::*;
#(
  parameter int NSRC = NUM_SRC
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src,
  input  logic [NSRC-1:0] src_en,
  input  logic [NSRC-1:0] clr,
  input  logic            auto_restart,
  output logic [NSRC-1:0] flags,
  output logic            active
);
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic set_i;
    logic drop_i;
    assign set_i  = src_en[i] & src[i];
    if (i == SRC_HALT) begin : g_halt
      assign drop_i = clr[i] | (auto_restart & ~src[i]);
    end else begin : g_plain
      assign drop_i = clr[i];
    end

    always_ff @(posedge clk) begin
      if (rst) flags[i] <= 1'b0;
      else     flags[i] <= set_i | (flags[i] & ~drop_i);
    end

    // R9
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
      (src_en[i] && src[i]) |=> flags[i]);
    // R9
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      (flags[i] && !clr[i] && !(i == SRC_HALT && auto_restart)) |=> flags[i]);
  end

  assign active = |flags;
endmodule

// File: rtl/dti_unit.sv
module dti_unit
  import dti_pkg::*;
#(
  parameter int NCH     = 3,
  parameter int DLY_W   = 8,
  parameter int SEL_W   = 4,
  parameter int PRE_MAX = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               enable,
  input  logic [NCH-1:0]     pwm_in,
  input  logic [SEL_W-1:0]   presc_sel,
  input  logic [DLY_W-1:0]   rise_dly,
  input  logic [DLY_W-1:0]   fall_dly,
  input  logic               pri_active_low,
  input  logic               cmp_invert,
  input  logic [2*NCH-1:0]   out_mask,
  input  logic [1:0]         fault_act,
  input  logic               lockup_in,
  input  logic               halt_in,
  input  logic [1:0]         ext_fault_in,
  input  logic [NUM_SRC-1:0] fault_src_en,
  input  logic [NUM_SRC-1:0] fault_clr,
  input  logic               auto_restart,
  output logic [NCH-1:0]     pri_out,
  output logic [NCH-1:0]     cmp_out,
  output logic [NCH-1:0]     pri_oe,
  output logic [NCH-1:0]     cmp_oe,
  output logic [NUM_SRC-1:0] fault_flags,
  output logic               fault_active
);
  logic           tick;
  logic [NCH-1:0] pri_act;
  logic [NCH-1:0] cmp_act;
  logic [NCH-1:0] pri_nx, cmp_nx, pri_oe_nx, cmp_oe_nx;
  fault_act_e     fa;

  dti_prescaler #(.PRE_MAX(PRE_MAX), .SEL_W(SEL_W)) presc_i (
    .clk(clk), .rst(rst), .en(enable), .sel(presc_sel), .tick(tick)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dti_channel #(.DLY_W(DLY_W)) ch_i (
      .clk(clk), .rst(rst), .en(enable), .tick(tick), .pwm(pwm_in[c]),
      .rise_dly(rise_dly), .fall_dly(fall_dly),
      .pri_act(pri_act[c]), .cmp_act(cmp_act[c])
    );
  end

  dti_fault #(.NSRC(NUM_SRC)) fault_i (
    .clk(clk), .rst(rst),
    .src({ext_fault_in[1], ext_fault_in[0], halt_in, lockup_in}),
    .src_en(fault_src_en), .clr(fault_clr), .auto_restart(auto_restart),
    .flags(fault_flags), .active(fault_active)
  );

  always_comb begin
    logic idle_p, idle_c;
    fa     = fault_act_e'(fault_act);
    idle_p = pri_active_low;
    idle_c = pri_active_low ^ cmp_invert;
    for (int i = 0; i < NCH; i++) begin
      pri_oe_nx[i] = out_mask[i];
      cmp_oe_nx[i] = out_mask[NCH+i];
      pri_nx[i]    = out_mask[i]     ? (pri_act[i] ^ idle_p) : idle_p;
      cmp_nx[i]    = out_mask[NCH+i] ? (cmp_act[i] ^ idle_c) : idle_c;
      if (!enable || (fault_active && fa == FA_TRISTATE)) begin
        pri_oe_nx[i] = 1'b0;
        cmp_oe_nx[i] = 1'b0;
        pri_nx[i]    = idle_p;
        cmp_nx[i]    = idle_c;
      end else if (fault_active && fa == FA_INACTIVE) begin
        pri_nx[i] = idle_p;
        cmp_nx[i] = idle_c;
      end else if (fault_active && fa == FA_CLEAR) begin
        pri_nx[i] = 1'b0;
        cmp_nx[i] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pri_out <= '0;
      cmp_out <= '0;
      pri_oe  <= '0;
      cmp_oe  <= '0;
    end else begin
      pri_out <= pri_nx;
      cmp_out <= cmp_nx;
      pri_oe  <= pri_oe_nx;
      cmp_oe  <= cmp_oe_nx;
    end
  end

  // R11
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (pri_oe == '0 && cmp_oe == '0));
  // R8
  tristate_chk: assert property (@(posedge clk) disable iff (rst)
    (fault_active && fault_act == 2'd3) |=> (pri_oe == '0 && cmp_oe == '0));
  // R7
  clear_action_chk: assert property (@(posedge clk) disable iff (rst)
    (enable && fault_active && fault_act == 2'd2) |=> (pri_out == '0 && cmp_out == '0));
  // R6
  mask_gate_chk: assert property (@(posedge clk) disable iff (rst)
    enable |=> ((pri_oe & ~$past(out_mask[NCH-1:0])) == '0 &&
                (cmp_oe & ~$past(out_mask[2*NCH-1:NCH])) == '0));
endmodule

// File: tb/dti_unit_tb.sv
module dti_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 3;
  localparam int DLY_W = 8;
  localparam int SEL_W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0;
  logic [NCH-1:0] pwm_in = '0;
  logic [SEL_W-1:0] presc_sel = '0;
  logic [DLY_W-1:0] rise_dly = '0, fall_dly = '0;
  logic pri_active_low = 1'b0, cmp_invert = 1'b0;
  logic [2*NCH-1:0] out_mask = '1;
  logic [1:0] fault_act = 2'd0;
  logic lockup_in = 1'b0, halt_in = 1'b0;
  logic [1:0] ext_fault_in = '0;
  logic [3:0] fault_src_en = '0, fault_clr = '0;
  logic auto_restart = 1'b0;
  logic [NCH-1:0] pri_out, cmp_out, pri_oe, cmp_oe;
  logic [3:0] fault_flags;
  logic fault_active;

  always #(CLK_PERIOD/2) clk = ~clk;

  dti_unit #(.NCH(NCH), .DLY_W(DLY_W), .SEL_W(SEL_W), .PRE_MAX(10)) dut_i (
    .clk(clk), .rst(rst), .enable(enable), .pwm_in(pwm_in), .presc_sel(presc_sel),
    .rise_dly(rise_dly), .fall_dly(fall_dly), .pri_active_low(pri_active_low),
    .cmp_invert(cmp_invert), .out_mask(out_mask), .fault_act(fault_act),
    .lockup_in(lockup_in), .halt_in(halt_in), .ext_fault_in(ext_fault_in),
    .fault_src_en(fault_src_en), .fault_clr(fault_clr), .auto_restart(auto_restart),
    .pri_out(pri_out), .cmp_out(cmp_out), .pri_oe(pri_oe), .cmp_oe(cmp_oe),
    .fault_flags(fault_flags), .fault_active(fault_active)
  );

  // Behavioural reference: ticks elapsed since each input last changed.
  int  m_div;
  int  m_since [NCH];
  bit  m_prev [NCH];
  bit  m_on_p [NCH];
  bit  m_on_c [NCH];
  bit  [3:0] m_flag;
  bit  [NCH-1:0] e_po, e_co, e_poe, e_coe;

  always @(posedge clk) begin
    if (rst) begin
      m_div = 0; m_flag = '0;
      e_po = '0; e_co = '0; e_poe = '0; e_coe = '0;
      for (int i = 0; i < NCH; i++) begin
        m_since[i] = 0; m_prev[i] = 0; m_on_p[i] = 0; m_on_c[i] = 0;
      end
    end else begin
      bit flt, tk, ip, ic;
      bit [3:0] srcs;
      int period;
      flt = (m_flag != 0);
      ip = pri_active_low;
      ic = pri_active_low ^ cmp_invert;
      for (int i = 0; i < NCH; i++) begin
        if (!enable || (flt && fault_act == 2'd3)) begin
          e_poe[i] = 0; e_coe[i] = 0; e_po[i] = ip; e_co[i] = ic;
        end else begin
          e_poe[i] = out_mask[i];
          e_coe[i] = out_mask[NCH+i];
          e_po[i] = out_mask[i] ? (m_on_p[i] ^ ip) : ip;
          e_co[i] = out_mask[NCH+i] ? (m_on_c[i] ^ ic) : ic;
          if (flt && fault_act == 2'd1) begin e_po[i] = ip; e_co[i] = ic; end
          if (flt && fault_act == 2'd2) begin e_po[i] = 0;  e_co[i] = 0;  end
        end
      end
      period = 1 << presc_sel;
      tk = enable && ((m_div % period) == period - 1);
      m_div = enable ? (m_div + 1) % 1024 : 0;
      for (int i = 0; i < NCH; i++) begin
        if (!enable) begin
          m_since[i] = 0; m_prev[i] = 0; m_on_p[i] = 0; m_on_c[i] = 0;
        end else begin
          int s, lim;
          s = (pwm_in[i] == m_prev[i]) ? m_since[i] : 0;
          lim = pwm_in[i] ? int'(rise_dly) : int'(fall_dly);
          m_on_p[i] = pwm_in[i] && (s >= lim);
          m_on_c[i] = !pwm_in[i] && (s >= lim);
          m_since[i] = (s < lim && tk) ? s + 1 : s;
          m_prev[i] = pwm_in[i];
        end
      end
      srcs = {ext_fault_in[1], ext_fault_in[0], halt_in, lockup_in};
      for (int k = 0; k < 4; k++) begin
        bit drop;
        drop = fault_clr[k] || (k == 1 && auto_restart && !srcs[k]);
        m_flag[k] = (fault_src_en[k] && srcs[k]) || (m_flag[k] && !drop);
      end
    end
  end

  int vectors = 0;
  int miscompares = 0;
  string cur_req = "R1";
  bit finished = 0;

  task automatic chk(string what, logic [NCH-1:0] act, logic [NCH-1:0] exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %b expected %b at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic cyc(int n);
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      vectors++;
      chk("pri_out", pri_out, e_po);
      chk("cmp_out", cmp_out, e_co);
      chk("pri_oe", pri_oe, e_poe);
      chk("cmp_oe", cmp_oe, e_coe);
      if (fault_flags !== m_flag || fault_active !== (m_flag != 0)) begin
        miscompares++;
        $display("FAIL %s flags: actual %b expected %b at %0t", cur_req, fault_flags, m_flag, $time);
      end
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    miscompares++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    // R1 reset state
    cur_req = "R1";
    cyc(3);
    rst = 0;
    enable = 1;
    // R2 separate rise/fall guard intervals, including short pulses
    cur_req = "R2";
    rise_dly = 3; fall_dly = 2;
    pwm_in = 3'b001; cyc(8);
    pwm_in = 3'b010; cyc(8);
    pwm_in = 3'b011; cyc(2);
    pwm_in = 3'b100; cyc(1);
    pwm_in = 3'b000; cyc(7);
    rise_dly = 0; fall_dly = 0;
    pwm_in = 3'b101; cyc(3);
    pwm_in = 3'b010; cyc(3);
    // R4 prescaled ticks
    cur_req = "R4";
    rise_dly = 2; fall_dly = 3; presc_sel = 2;
    for (int r = 0; r < 6; r++) begin
      pwm_in = ~pwm_in; cyc(13 + r);
    end
    presc_sel = 1; pwm_in = 3'b111; cyc(9);
    presc_sel = 0;
    // R3 stress with random inputs
    cur_req = "R3";
    rise_dly = 1; fall_dly = 1;
    for (int r = 0; r < 300; r++) begin
      pwm_in = NCH'($urandom);
      cyc(1 + ($urandom % 3));
    end
    // R5 polarity combinations
    cur_req = "R5";
    rise_dly = 2; fall_dly = 1;
    for (int p = 0; p < 4; p++) begin
      pri_active_low = p[0]; cmp_invert = p[1];
      pwm_in = 3'b101; cyc(6);
      pwm_in = 3'b010; cyc(6);
    end
    pri_active_low = 0; cmp_invert = 0;
    // R6 mask gating
    cur_req = "R6";
    out_mask = 6'b101010; pwm_in = 3'b111; cyc(5);
    pwm_in = 3'b000; cyc(5);
    pri_active_low = 1; out_mask = 6'b010101; pwm_in = 3'b110; cyc(6);
    pri_active_low = 0; out_mask = '1;
    // R7 inactive action, fault landing on the guard-expiry cycle
    cur_req = "R7";
    fault_act = 2'd1; fault_src_en = 4'b0100;
    pwm_in = 3'b000; cyc(4);
    pwm_in = 3'b111; cyc(1);
    ext_fault_in = 2'b01; cyc(1);
    ext_fault_in = 2'b00; cyc(6);
    fault_act = 2'd2; pri_active_low = 1; cyc(4);
    fault_act = 2'd0; cyc(3);
    pri_active_low = 0;
    fault_clr = 4'b0100; cyc(1);
    fault_clr = 4'b0000; cyc(3);
    // R9 unenabled source ignored; clear coinciding with set
    cur_req = "R9";
    fault_src_en = 4'b0001; fault_act = 2'd1;
    ext_fault_in = 2'b10; cyc(3);
    ext_fault_in = 2'b00; cyc(2);
    lockup_in = 1; fault_clr = 4'b0001; cyc(1);
    lockup_in = 0; fault_clr = 4'b0000; cyc(4);
    fault_clr = 4'b0001; cyc(1);
    fault_clr = 4'b0000; cyc(3);
    // R8 tristate action
    cur_req = "R8";
    fault_act = 2'd3; fault_src_en = 4'b1000;
    ext_fault_in = 2'b10; cyc(1);
    ext_fault_in = 2'b00; pwm_in = 3'b010; cyc(6);
    fault_clr = 4'b1000; cyc(1);
    fault_clr = 4'b0000; cyc(5);
    // R10 halt flag with and without auto-restart
    cur_req = "R10";
    fault_act = 2'd1; fault_src_en = 4'b0010;
    halt_in = 1; cyc(3);
    halt_in = 0; cyc(4);
    auto_restart = 1; cyc(2);
    halt_in = 1; cyc(3);
    halt_in = 0; cyc(4);
    auto_restart = 0; fault_src_en = '0;
    // R11 disable
    cur_req = "R11";
    enable = 0; pwm_in = 3'b101; cyc(5);
    pri_active_low = 1; cyc(2);
    pri_active_low = 0; enable = 1; cyc(8);
    summary();
  end
endmodule